// File: doc/BRIEF.md
# Interleaved Carrier Rate Overrun Checker

This block guards one mixing lane that carries up to four time-interleaved carrier slots. Each slot has an enable and a two-bit rate code, and the rate is a power-of-two fraction of the core clock, from one sixteenth up to one half. Every cycle the block turns the enabled slots into weights in sixteenths of the clock and adds them. It raises an overrun when the total load is more than one full clock of capacity.

When an overrun starts, the block gives a single-cycle event pulse. Together with the pulse it reports which slot caused the problem and the antenna tag of the lane. The slot reported is the first one, walking upward from slot 0, at which the running load goes past the limit. The configuration pins are plain level inputs and the block samples them on every clock, so a change to the configuration is judged on the next edge. No data stream passes through the block, so it has no valid/ready handshake and never applies back-pressure. All outputs are registered and show the configuration from one cycle earlier.

Top module: `rate_overrun_chk`

## Requirements
- R1: Rate code 0, 1, 2 and 3 add 1, 2, 4 and 8 units of Fc/16 to the lane load. The load is shown on `lane_load`.
- R2: A slot whose bit in `slot_en` is 0 adds nothing to the load, whatever its rate code is. Slot i uses `slot_en[i]` and `slot_rate[2*i+1:2*i]`.
- R3: `overrun` is 1 exactly when the load is strictly greater than 16 units. A load of exactly 16 is legal.
- R4: `overrun_evt` is high for one cycle on the cycle in which `overrun` goes from 0 to 1. It stays low while the overrun continues, and it pulses again only after the overrun has cleared and then returned.
- R5: While `overrun` is 1, `ovr_slot` gives the lowest-numbered enabled slot at which the running load, summed in ascending slot order, first goes above 16. While `overrun` is 0, `ovr_slot` is 0.
- R6: While `overrun` is 1, `ovr_ant` holds the `ant_tag` that was sampled with the same configuration. Otherwise `ovr_ant` is 0.
- R7: While `rst_n` is low, all outputs are 0.
- R8: All outputs update on the clock edge after the configuration is sampled, so the latency is one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_en | input | NSLOT | Per-slot enable |
| slot_rate | input | 2*NSLOT | Per-slot rate code, two bits per slot |
| ant_tag | input | ANT_W | Antenna identity of this lane |
| lane_load | output | SUM_W | Registered total load in units of Fc/16 |
| overrun | output | 1 | Load exceeds the clock rate |
| overrun_evt | output | 1 | One-cycle pulse when an overrun starts |
| ovr_slot | output | ID_W | First offending slot |
| ovr_ant | output | ANT_W | Antenna tag captured with the overrun |

## Verification
The assertions check on every cycle that `overrun` agrees with `lane_load` against the limit. They also check that an event pulse only comes on a rising overrun and never twice in a row, that the reported slot was enabled, and that the slot and antenna fields stay 0 when there is no overrun. The bench scenarios are needed to show the exact weight of each rate code, that a total of exactly 16 is legal, and which slot is chosen when disabled slots sit between enabled ones. They also show that the event fires again after the overrun clears and comes back.

// File: rtl/rate_ovr_pkg.sv
package rate_ovr_pkg;
  typedef enum logic [1:0] {
    RATE_DIV16 = 2'd0,
    RATE_DIV8  = 2'd1,
    RATE_DIV4  = 2'd2,
    RATE_DIV2  = 2'd3
  } rate_code_e;

  localparam int unsigned MAX_WEIGHT = 8;
endpackage

// File: rtl/slot_weight.sv
module slot_weight
  import rate_ovr_pkg::*;
#(
  parameter int SUM_W = 6
) (
  input  logic             en,
  input  logic [1:0]       code,
  output logic [SUM_W-1:0] weight
);
  rate_code_e rc;
  assign rc = rate_code_e'(code);

  always_comb begin
    weight = '0;
    if (en) begin
      unique case (rc)
        RATE_DIV16: weight = SUM_W'(1);
        RATE_DIV8:  weight = SUM_W'(2);
        RATE_DIV4:  weight = SUM_W'(4);
        RATE_DIV2:  weight = SUM_W'(8);
        default:    weight = '0;
      endcase
    end
  end
endmodule

// File: rtl/rate_accum.sv
module rate_accum #(
  parameter int NSLOT = 4,
  parameter int SUM_W = 6,
  parameter int ID_W  = 2,
  parameter int LIMIT = 16
) (
  input  logic [NSLOT-1:0][SUM_W-1:0] weights,
  output logic [SUM_W-1:0]            total,
  output logic                        over,
  output logic [ID_W-1:0]             first_id
);
  localparam logic [SUM_W-1:0] LIM_V = SUM_W'(LIMIT);

  logic [SUM_W-1:0] run;
  logic             found;

  always_comb begin
    run      = '0;
    found    = 1'b0;
    first_id = '0;
    for (int i = 0; i < NSLOT; i++) begin
      run = run + weights[i];
      if (!found && (run > LIM_V)) begin
        found    = 1'b1;
        first_id = ID_W'(i);
      end
    end
    total = run;
    over  = found;
  end
endmodule

// File: rtl/rate_overrun_chk.sv
module rate_overrun_chk
  import rate_ovr_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int ANT_W = 3,
  parameter int LIMIT = 16,
  localparam int SUM_W = $clog2(NSLOT * MAX_WEIGHT + 1),
  localparam int ID_W  = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSLOT-1:0]   slot_en,
  input  logic [2*NSLOT-1:0] slot_rate,
  input  logic [ANT_W-1:0]   ant_tag,
  output logic [SUM_W-1:0]   lane_load,
  output logic               overrun,
  output logic               overrun_evt,
  output logic [ID_W-1:0]    ovr_slot,
  output logic [ANT_W-1:0]   ovr_ant
);
  logic [NSLOT-1:0][SUM_W-1:0] w;
  logic [SUM_W-1:0]            sum_c;
  logic                        over_c;
  logic [ID_W-1:0]             id_c;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    slot_weight #(.SUM_W(SUM_W)) u_w (
      .en     (slot_en[g]),
      .code   (slot_rate[2*g +: 2]),
      .weight (w[g])
    );
  end

  rate_accum #(
    .NSLOT(NSLOT), .SUM_W(SUM_W), .ID_W(ID_W), .LIMIT(LIMIT)
  ) u_acc (
    .weights  (w),
    .total    (sum_c),
    .over     (over_c),
    .first_id (id_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_load   <= '0;
      overrun     <= 1'b0;
      overrun_evt <= 1'b0;
      ovr_slot    <= '0;
      ovr_ant     <= '0;
    end else begin
      lane_load   <= sum_c;
      overrun     <= over_c;
      overrun_evt <= over_c & ~overrun;
      ovr_slot    <= over_c ? id_c : '0;
      ovr_ant     <= over_c ? ant_tag : '0;
    end
  end
endmodule

// File: rtl/rate_ovr_checker.sv
module rate_ovr_checker #(
  parameter int NSLOT = 4,
  parameter int ANT_W = 3,
  parameter int LIMIT = 16,
  parameter int SUM_W = 6,
  parameter int ID_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSLOT-1:0] slot_en,
  input logic [ANT_W-1:0] ant_tag,
  input logic [SUM_W-1:0] lane_load,
  input logic             overrun,
  input logic             overrun_evt,
  input logic [ID_W-1:0]  ovr_slot,
  input logic [ANT_W-1:0] ovr_ant
);
  logic             armed;
  logic [NSLOT-1:0] en_prev;
  logic [ANT_W-1:0] ant_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      en_prev  <= '0;
      ant_prev <= '0;
    end else begin
      armed    <= 1'b1;
      en_prev  <= slot_en;
      ant_prev <= ant_tag;
    end
  end

  a_r3_level_vs_load: assert property (@(posedge clk) disable iff (!rst_n)
    overrun == (lane_load > SUM_W'(LIMIT)));

  a_r4_evt_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |-> overrun && !$past(overrun));

  a_r4_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> !overrun_evt);

  a_r5_slot_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && overrun) |-> en_prev[ovr_slot]);

  a_r5_quiet_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !overrun |-> (ovr_slot == '0) && (ovr_ant == '0));

  a_r6_ant_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && overrun) |-> ovr_ant == ant_prev);

  a_r2_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && en_prev == '0) |-> lane_load == '0);
endmodule

bind rate_overrun_chk rate_ovr_checker #(
  .NSLOT(NSLOT), .ANT_W(ANT_W), .LIMIT(LIMIT), .SUM_W(SUM_W), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .ant_tag(ant_tag),
  .lane_load(lane_load), .overrun(overrun), .overrun_evt(overrun_evt),
  .ovr_slot(ovr_slot), .ovr_ant(ovr_ant)
);

// File: tb/sim_rate_overrun_chk.sv
`timescale 1ns/1ps
module sim_rate_overrun_chk;
  localparam int NSLOT = 4;
  localparam int ANT_W = 3;
  localparam int SUM_W = 6;
  localparam int ID_W  = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NSLOT-1:0]   slot_en = '0;
  logic [2*NSLOT-1:0] slot_rate = '0;
  logic [ANT_W-1:0]   ant_tag = '0;
  logic [SUM_W-1:0]   lane_load;
  logic               overrun, overrun_evt;
  logic [ID_W-1:0]    ovr_slot;
  logic [ANT_W-1:0]   ovr_ant;

  int checks = 0;
  int fails  = 0;
  logic exp_prev_over = 1'b0;

  always #10 clk = ~clk;

  rate_overrun_chk u0 (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .slot_rate(slot_rate),
    .ant_tag(ant_tag), .lane_load(lane_load), .overrun(overrun),
    .overrun_evt(overrun_evt), .ovr_slot(ovr_slot), .ovr_ant(ovr_ant)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one configuration, wait for the registering edge, check at negedge.
  task automatic apply(input logic [3:0] en, input logic [7:0] rate,
                       input logic [2:0] ant, input string req);
    int run, id, exp_ev;
    logic over;
    slot_en = en; slot_rate = rate; ant_tag = ant;
    run = 0; id = 0; over = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (en[i]) run += (1 << rate[2*i +: 2]);
      if (!over && run > 16) begin over = 1'b1; id = i; end
    end
    exp_ev = (over && !exp_prev_over) ? 1 : 0;
    @(posedge clk); @(negedge clk);
    check({req, " load"},    int'(lane_load),   run);
    check({req, " overrun"}, int'(overrun),     int'(over));
    check({req, " evt"},     int'(overrun_evt), exp_ev);
    check({req, " slot"},    int'(ovr_slot),    over ? id : 0);
    check({req, " ant"},     int'(ovr_ant),     over ? int'(ant) : 0);
    exp_prev_over = over;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R7 load", int'(lane_load), 0);
    check("R7 overrun", int'(overrun), 0);
    check("R7 evt", int'(overrun_evt), 0);
    check("R7 slot", int'(ovr_slot), 0);
  endtask

  task automatic t_weights();
    apply(4'b0001, 8'h00, 3'd1, "R1 code0");
    apply(4'b0001, 8'h01, 3'd1, "R1 code1");
    apply(4'b0001, 8'h02, 3'd1, "R1 code2");
    apply(4'b0001, 8'h03, 3'd1, "R1 code3");
    apply(4'b1111, 8'b00_01_10_11, 3'd1, "R8 mixed 15");
  endtask

  task automatic t_disabled();
    apply(4'b0000, 8'hFF, 3'd2, "R2 all off");
    apply(4'b0101, 8'hFF, 3'd2, "R2 R3 two of four at 16");
  endtask

  task automatic t_boundary();
    apply(4'b1111, 8'b01_01_10_11, 3'd4, "R3 exact 16");
    apply(4'b1111, 8'b00_10_10_11, 3'd5, "R3 R4 R5 first over 17");
    apply(4'b1111, 8'b00_10_10_11, 3'd5, "R4 held no repeat");
  endtask

  task automatic t_ident();
    apply(4'b0000, 8'h00, 3'd0, "R4 clear");
    apply(4'b0111, 8'b00_00_11_11, 3'd6, "R5 slot2 pushes");
    apply(4'b0000, 8'h00, 3'd0, "R4 clear again");
    apply(4'b1011, 8'b01_11_11_11, 3'd7, "R5 R6 skip disabled slot");
    apply(4'b1111, 8'b11_11_11_11, 3'd3, "R5 R6 still over slot move");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_weights();
    t_disabled();
    t_boundary();
    t_ident();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule